// File: doc/BRIEF.md
# Triangle-Swept Spread-Spectrum Clock Divider

This block divides a fast reference clock into a slower output clock whose period is swept up and down in a triangle pattern. Spreading the output frequency around a nominal value in this way lowers its peak spectral energy. Every output cycle lasts `base + index * step` reference ticks. A step index moves up by one per output cycle until it reaches a configured ceiling. It then moves down by one per cycle to zero, and the sweep repeats. One full rise and fall of the index is one modulation period.

The base period, per-step increment and index ceiling are input ports in units of reference ticks. They are sampled only on the last reference tick of each output cycle, so a cycle that has already started is never shortened or stretched. A spread enable selects between the swept clock and a fixed clock at the base period. When spreading is turned back on, the sweep restarts from index zero going up. The block drives a true output and a complementary output, both from registers.

Top module: `ssc_clkdiv`

## Requirements
- R1: With spreading on, each output cycle lasts base + index * step reference ticks, where index is that cycle's step index.
- R2: After reset the step index runs 0, 1, ... up to the ceiling and then back down to 0. Each end value appears exactly once per turn: at the ceiling the next change is a decrement, and at 0 the next change is an increment.
- R3: With a ceiling of 0 the index stays at 0, so every cycle lasts the base period.
- R4: Every output cycle begins high. It stays high for ceil(P/2) ticks and is low for floor(P/2) ticks, where P is the cycle's period.
- R5: A base period below 2 is treated as 2.
- R6: With spreading off, every cycle lasts the base period. The index is held at 0 and the direction at up.
- R7: Configuration and enable values take effect only at a cycle boundary. The values present on the last tick of an output cycle decide the next cycle, and a change made inside a cycle does not alter that cycle.
- R8: The first cycle after spreading is turned back on uses index 0, and the next uses index 1.
- R9: The complementary output is always the inverse of the true output.
- R10: The active-low reset is asynchronous and its release is synchronised. During reset the true output is high and the complementary output is low. The first cycle after release uses index 0 and its low phase lasts floor(base/2) ticks.
- R11: If the ceiling is lowered below the index while the index is climbing, the index turns and falls by one at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | 1 selects the triangle sweep, 0 the fixed base period |
| base_ticks | input | BASE_W | Base period in reference ticks |
| step_ticks | input | STEP_W | Period increment per index step |
| max_idx | input | IDX_W | Index ceiling of the sweep |
| clk_out | output | 1 | Swept output clock |
| clk_out_n | output | 1 | Inverse of clk_out |

## Verification
Two situations are hard to reach from the ports. One is a ceiling that drops below the index while the index is climbing. The other is spreading coming back on after some bypass cycles. The stimulus waits for each output rising edge and tracks a reference model of the sweep. It can therefore choose the exact cycle in which to lower the ceiling or flip the enable. Because every change lands inside a running cycle, the same stimulus also shows that the cycle in progress is left untouched. Random configuration changes are mixed in at rising edges to cover odd and even periods, zero steps and base values below 2.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } sweep_dir_e;

  localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/ssc_rst_sync.sv
module ssc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/ssc_sweep_seq.sv
module ssc_sweep_seq
  import ssc_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first,
  input  logic             boundary,
  input  logic             spread_en,
  input  logic [IDX_W-1:0] max_idx,
  output logic [IDX_W-1:0] idx_nxt
);

  logic [IDX_W-1:0] idx_q, idx_d;
  sweep_dir_e       dir_q, dir_d;
  logic             swept_q, swept_d;
  logic             step_en;

  assign step_en = first | boundary;

  always_comb begin
    idx_d   = idx_q;
    dir_d   = dir_q;
    swept_d = swept_q;
    if (first) begin
      idx_d   = '0;
      dir_d   = DIR_UP;
      swept_d = spread_en;
    end else if (boundary) begin
      if (!spread_en) begin
        idx_d   = '0;
        dir_d   = DIR_UP;
        swept_d = 1'b0;
      end else if (!swept_q) begin
        idx_d   = '0;
        dir_d   = DIR_UP;
        swept_d = 1'b1;
      end else if (dir_q == DIR_UP) begin
        if (idx_q < max_idx) begin
          idx_d = idx_q + 1'b1;
        end else if (idx_q != '0) begin
          idx_d = idx_q - 1'b1;
          dir_d = DIR_DN;
        end
      end else begin
        if (idx_q != '0) begin
          idx_d = idx_q - 1'b1;
        end else if (max_idx != '0) begin
          idx_d = idx_q + 1'b1;
          dir_d = DIR_UP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      dir_q   <= DIR_UP;
      swept_q <= 1'b1;
    end else if (step_en) begin
      idx_q   <= idx_d;
      dir_q   <= dir_d;
      swept_q <= swept_d;
    end
  end

  assign idx_nxt = idx_d;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(idx_q) && $stable(dir_q)));

  p_bypass_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !spread_en) |=> (idx_q == '0 && dir_q == DIR_UP));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && spread_en && !swept_q) |=> (idx_q == '0 && dir_q == DIR_UP));

  p_turn_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && spread_en && swept_q && dir_q == DIR_UP &&
     idx_q >= max_idx && idx_q != '0)
    |=> (dir_q == DIR_DN && idx_q == $past(idx_q) - 1'b1));

  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1 ||
                  idx_q == $past(idx_q) - 1'b1 || idx_q == '0));

endmodule

// File: rtl/ssc_period_gen.sv
module ssc_period_gen
  import ssc_pkg::*;
#(
  parameter int unsigned BASE_W = 12,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned PER_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] base_ticks,
  input  logic [STEP_W-1:0] step_ticks,
  input  logic [IDX_W-1:0]  idx_nxt,
  output logic              boundary,
  output logic              first,
  output logic              out_q,
  output logic              out_n_q
);

  logic             run_q;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] hi_q, hi_d;
  logic             out_d;
  logic [PER_W-1:0] base_eff;
  logic [PER_W-1:0] per_nxt;
  logic [PER_W:0]   per_plus1;
  logic [PER_W-1:0] hi_nxt;
  logic [PER_W-1:0] cnt_inc;
  logic             load;

  always_comb begin
    base_eff = PER_W'(base_ticks);
    if (base_eff < PER_W'(MIN_PERIOD)) base_eff = PER_W'(MIN_PERIOD);
  end

  assign per_nxt   = base_eff + (PER_W'(idx_nxt) * PER_W'(step_ticks));
  assign per_plus1 = {1'b0, per_nxt} + 1'b1;
  assign hi_nxt    = per_plus1[PER_W:1];

  assign boundary = run_q && (cnt_q == per_q - 1'b1);
  assign first    = !run_q;
  assign load     = boundary | first;
  assign cnt_inc  = cnt_q + 1'b1;

  always_comb begin
    if (load) begin
      cnt_d = '0;
      per_d = per_nxt;
      hi_d  = hi_nxt;
      out_d = 1'b1;
    end else begin
      cnt_d = cnt_inc;
      per_d = per_q;
      hi_d  = hi_q;
      out_d = (cnt_inc < hi_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      per_q   <= PER_W'(MIN_PERIOD);
      hi_q    <= PER_W'(1);
      out_q   <= 1'b1;
      out_n_q <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      hi_q    <= hi_d;
      out_q   <= out_d;
      out_n_q <= !out_d;
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));

  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q >= PER_W'(MIN_PERIOD)));

  p_no_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !boundary) |=> ($stable(per_q) && $stable(hi_q)));

  p_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> out_q);

  p_fall_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !boundary && !out_q) |=> !out_q);

endmodule

// File: rtl/ssc_clkdiv.sv
module ssc_clkdiv
  import ssc_pkg::*;
#(
  parameter int unsigned BASE_W      = 12,
  parameter int unsigned STEP_W      = 8,
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              spread_en,
  input  logic [BASE_W-1:0] base_ticks,
  input  logic [STEP_W-1:0] step_ticks,
  input  logic [IDX_W-1:0]  max_idx,
  output logic              clk_out,
  output logic              clk_out_n
);

  localparam int unsigned PROD_W = STEP_W + IDX_W;
  localparam int unsigned PER_W  = ((BASE_W > PROD_W) ? BASE_W : PROD_W) + 1;

  logic             srst_n;
  logic             boundary;
  logic             first;
  logic [IDX_W-1:0] idx_nxt;

  ssc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk    (clk_ref),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ssc_sweep_seq #(
    .IDX_W (IDX_W)
  ) u_seq (
    .clk       (clk_ref),
    .rst_n     (srst_n),
    .first     (first),
    .boundary  (boundary),
    .spread_en (spread_en),
    .max_idx   (max_idx),
    .idx_nxt   (idx_nxt)
  );

  ssc_period_gen #(
    .BASE_W (BASE_W),
    .STEP_W (STEP_W),
    .IDX_W  (IDX_W),
    .PER_W  (PER_W)
  ) u_per (
    .clk        (clk_ref),
    .rst_n      (srst_n),
    .base_ticks (base_ticks),
    .step_ticks (step_ticks),
    .idx_nxt    (idx_nxt),
    .boundary   (boundary),
    .first      (first),
    .out_q      (clk_out),
    .out_n_q    (clk_out_n)
  );

  p_compl_r9: assert property (@(posedge clk_ref) disable iff (!srst_n)
    clk_out_n == !clk_out);

  p_reset_level_r10: assert property (@(posedge clk_ref) disable iff (rst_n)
    (clk_out && !clk_out_n));

endmodule

// File: tb/sim_ssc_clkdiv.sv
`timescale 1ns/1ps
module sim_ssc_clkdiv;

  localparam int BASE_W = 12;
  localparam int STEP_W = 8;
  localparam int IDX_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              spread_en;
  logic [BASE_W-1:0] base_ticks;
  logic [STEP_W-1:0] step_ticks;
  logic [IDX_W-1:0]  max_idx;
  logic              clk_out, clk_out_n;

  always #4 clk = ~clk;

  ssc_clkdiv #(.BASE_W(BASE_W), .STEP_W(STEP_W), .IDX_W(IDX_W)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .spread_en(spread_en),
    .base_ticks(base_ticks), .step_ticks(step_ticks), .max_idx(max_idx),
    .clk_out(clk_out), .clk_out_n(clk_out_n)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    m_idx, m_dir, m_sw, exp_p;
  string exp_tag;
  bit    done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_base(input int b);
    return (b < 2) ? 2 : b;
  endfunction

  // reference model of the next cycle, from the inputs present at the boundary
  task automatic model_step();
    int mx;
    mx = int'(max_idx);
    exp_tag = "R1";
    if (!spread_en) begin
      m_idx = 0; m_dir = 0; m_sw = 0; exp_tag = "R6";
    end else if (m_sw == 0) begin
      m_idx = 0; m_dir = 0; m_sw = 1; exp_tag = "R8";
    end else if (m_dir == 0) begin
      if (m_idx < mx) m_idx++;
      else if (m_idx != 0) begin
        exp_tag = (m_idx > mx) ? "R11" : "R2";
        m_dir = 1; m_idx--;
      end
    end else begin
      if (m_idx > 0) m_idx--;
      else if (mx != 0) begin m_dir = 0; m_idx++; exp_tag = "R2"; end
    end
    if (spread_en && mx == 0 && exp_tag == "R1") exp_tag = "R3";
    exp_p = eff_base(int'(base_ticks)) + m_idx * int'(step_ticks);
    if (int'(base_ticks) < 2) exp_tag = "R5";
  endtask

  // called right after an observed rising edge; changes land mid-cycle
  task automatic set_cfg(input int en, input int b, input int s, input int mx);
    if (en != int'(spread_en) || b != int'(base_ticks) ||
        s != int'(step_ticks) || mx != int'(max_idx))
      exp_tag = {exp_tag, "/R7"};
    spread_en  = en[0];
    base_ticks = BASE_W'(b);
    step_ticks = STEP_W'(s);
    max_idx    = IDX_W'(mx);
  endtask

  // positioned at the first high sample of a cycle; measures it fully
  task automatic run_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      int hi, lo, cm;
      hi = 1; lo = 0; cm = 0;
      forever begin
        @(negedge clk);
        if (clk_out_n == clk_out) cm++;
        if (!clk_out) break;
        hi++;
      end
      lo = 1;
      forever begin
        @(negedge clk);
        if (clk_out_n == clk_out) cm++;
        if (clk_out) break;
        lo++;
      end
      chk({"R4 high ", exp_tag}, hi, (exp_p + 1) / 2);
      chk({"R4 low ", exp_tag}, lo, exp_p / 2);
      chk({"period ", exp_tag}, hi + lo, exp_p);
      chk("R9 complement mismatches", cm, 0);
      model_step();
    end
  endtask

  task automatic do_reset(input int en, input int b, input int s, input int mx);
    int lo;
    @(negedge clk);
    rst_n = 1'b0;
    spread_en = en[0]; base_ticks = BASE_W'(b);
    step_ticks = STEP_W'(s); max_idx = IDX_W'(mx);
    repeat (4) @(negedge clk);
    chk("R10 reset clk_out", int'(clk_out), 1);
    chk("R10 reset clk_out_n", int'(clk_out_n), 0);
    rst_n = 1'b1;
    m_idx = 0; m_dir = 0; m_sw = en;
    exp_p = eff_base(b);
    do @(negedge clk); while (clk_out);
    lo = 1;
    forever begin
      @(negedge clk);
      if (clk_out) break;
      lo++;
    end
    chk("R10 first cycle low", lo, exp_p / 2);
    model_step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b1;
    spread_en = 1'b1; base_ticks = '0; step_ticks = '0; max_idx = '0;

    // basic triangle sweep
    do_reset(1, 6, 2, 3);
    run_cycles(16);

    // odd base, ceiling 0
    set_cfg(1, 7, 3, 0);
    run_cycles(8);

    // base below the floor
    set_cfg(1, 0, 1, 2);
    run_cycles(6);
    set_cfg(1, 1, 0, 2);
    run_cycles(4);

    // bypass and re-enable
    set_cfg(1, 10, 1, 4);
    run_cycles(6);
    set_cfg(0, 10, 1, 4);
    run_cycles(4);
    set_cfg(1, 10, 1, 4);
    run_cycles(8);

    // lower the ceiling while climbing
    set_cfg(1, 5, 2, 5);
    for (int g = 0; g < 24; g++) begin
      if (m_idx == 4 && m_dir == 0) break;
      run_cycles(1);
    end
    set_cfg(1, 5, 2, 2);
    run_cycles(10);

    // random changes at rising edges
    for (int r = 0; r < 300; r++) begin
      if ($urandom_range(0, 9) < 3)
        set_cfg(($urandom_range(0, 99) < 85) ? 1 : 0,
                $urandom_range(0, 20), $urandom_range(0, 7),
                $urandom_range(0, 6));
      run_cycles(1);
    end

    // reset while running
    do_reset(1, 9, 1, 2);
    run_cycles(10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule